// File: doc/BRIEF.md
# Fixed-Latency Interrupt Entry Controller

This block steers a three-stage (fetch, decode, execute) pipelined 16-bit core into an interrupt handler. It always takes the same number of clock edges to do so, whatever instruction is in flight. A set of asynchronous request lines is sampled once, with no multi-stage synchronizer. The rising edge that sees a request while the global enable is set is the recognition edge. The pending line with the lowest index is chosen at that edge.

In the cycle after recognition, the block does three things. It squashes the fetch and decode stages so they become bubbles. It reads the chosen source's handler address from an external synchronous vector table. It acknowledges the chosen source. At the next edge it copies two values into shadow registers: the program counter of the decode-stage instruction, which is the oldest squashed one and so is re-executed on return, and the status word. In the same step it clears the global enable bit. In the cycle that follows, it presents the vector to the program counter load path. The PC takes the vector on the third edge counted from recognition, and the handler's first fetch starts on that same edge.

The result is a request-to-vector delay of more than two and less than three clock periods for a request that arrives between edges. Software re-enables interrupts by writing the status word through the ordinary write port.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, flush_fetch, flush_decode, vec_rd_en and pc_load_en are low, irq_ack is zero, ret_pc and saved_psw are zero and psw holds its reset value 0 (global enable, bit 0, clear).
- R2: A rising edge that sees any irq_req line high while psw bit 0 is set and no entry is in progress is the recognition edge. flush_fetch and flush_decode are then high for exactly the two following cycles.
- R3: In the first cycle after recognition, vec_rd_en is high. vec_rd_idx is the chosen source index, and irq_ack is one-hot with the bit of that index set. In all other cycles vec_rd_en is low and irq_ack is zero.
- R4: In the second cycle after recognition, pc_load_en is high and pc_load_val equals vec_rd_data, which the table returns one edge after the read. The time from a request's arrival to the edge that loads the PC is therefore more than two and less than three clock periods.
- R5: When several lines are high at the recognition edge, the lowest set index is chosen.
- R6: ret_pc takes the value of pc_decode present during the first cycle after recognition.
- R7: At the second edge after recognition, two things happen. saved_psw takes the status word as updated by any psw_wr_en write in that same cycle. psw takes the same value with bit 0 cleared, and all other bits are kept.
- R8: While psw bit 0 is clear, requests have no effect: no flush, no vector read and no PC load, and psw is unchanged.
- R9: A request held high during an entry does not restart it. It can start a new entry only from the first edge after pc_load_en, and only if bit 0 has been set again by then.
- R10: Outside the save edge, a psw_wr_en pulse loads psw_wr_data into psw at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Asynchronous request lines, index 0 highest priority |
| pc_decode | input | PC_W | PC of the instruction in the decode stage |
| psw_wr_en | input | 1 | Status word write strobe from the execute stage |
| psw_wr_data | input | PSW_W | Status word write value |
| vec_rd_en | output | 1 | Vector table read strobe |
| vec_rd_idx | output | IDX_W | Vector table read index (chosen source) |
| vec_rd_data | input | PC_W | Vector table data, valid one edge after the read |
| flush_fetch | output | 1 | Squash the fetch stage |
| flush_decode | output | 1 | Squash the decode stage |
| pc_load_en | output | 1 | Load the PC with pc_load_val at the next edge |
| pc_load_val | output | PC_W | Handler start address |
| irq_ack | output | NUM_SRC | One-hot acknowledge of the chosen source |
| psw | output | PSW_W | Current status word, bit 0 is the global enable |
| ret_pc | output | PC_W | Saved return address |
| saved_psw | output | PSW_W | Saved status word |

## Verification
Two functions can fall in the same cycle. The hardware save of the status word, with its clear of the enable bit, can meet a status write from the instruction that is finishing in execute. The bench provokes this by pulsing psw_wr_en in the first cycle after recognition, with values that both set and clear bit 0. It then judges saved_psw against the written value and psw against that value with bit 0 forced low. A second overlap is also driven: a request held through the load cycle while software re-enables interrupts in that same cycle. That request must not disturb the running entry, and it must start the next entry exactly one edge later.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE  = 2'd0,
        ENT_ABORT = 2'd1,
        ENT_LOAD  = 2'd2
    } ent_state_e;

    typedef struct packed {
        logic squash;
        logic vec_rd;
        logic pc_load;
        logic save;
    } ent_ctl_t;

    function automatic ent_ctl_t ctl_of(input ent_state_e st);
        ent_ctl_t c;
        c = '0;
        case (st)
            ENT_ABORT: begin
                c.squash = 1'b1;
                c.vec_rd = 1'b1;
                c.save   = 1'b1;
            end
            ENT_LOAD: begin
                c.squash  = 1'b1;
                c.pc_load = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [IDX_W-1:0] pick_idx,
    output ent_state_e       state,
    output logic [IDX_W-1:0] src
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENT_IDLE;
            src   <= '0;
        end else begin
            case (state)
                ENT_IDLE: begin
                    if (take) begin
                        state <= ENT_ABORT;
                        src   <= pick_idx;
                    end
                end
                ENT_ABORT: state <= ENT_LOAD;
                ENT_LOAD:  state <= ENT_IDLE;
                default:   state <= ENT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_ctx_save.sv
module irq_ctx_save #(
    parameter int               PC_W    = 16,
    parameter int               PSW_W   = 16,
    parameter int               GIE_BIT = 0,
    parameter logic [PSW_W-1:0] PSW_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save,
    input  logic [PC_W-1:0]  pc_decode,
    input  logic             psw_wr_en,
    input  logic [PSW_W-1:0] psw_wr_data,
    output logic [PSW_W-1:0] psw,
    output logic [PC_W-1:0]  ret_pc,
    output logic [PSW_W-1:0] saved_psw
);
    localparam logic [PSW_W-1:0] GIE_MASK = PSW_W'(1) << GIE_BIT;

    logic [PSW_W-1:0] psw_next;

    always_comb begin
        psw_next = psw_wr_en ? psw_wr_data : psw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw       <= PSW_RST;
            ret_pc    <= '0;
            saved_psw <= '0;
        end else if (save) begin
            ret_pc    <= pc_decode;
            saved_psw <= psw_next;
            psw       <= psw_next & ~GIE_MASK;
        end else begin
            psw <= psw_next;
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 16,
    parameter int PSW_W   = 16,
    parameter int GIE_BIT = 0,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [PC_W-1:0]    pc_decode,
    input  logic               psw_wr_en,
    input  logic [PSW_W-1:0]   psw_wr_data,
    output logic               vec_rd_en,
    output logic [IDX_W-1:0]   vec_rd_idx,
    input  logic [PC_W-1:0]    vec_rd_data,
    output logic               flush_fetch,
    output logic               flush_decode,
    output logic               pc_load_en,
    output logic [PC_W-1:0]    pc_load_val,
    output logic [NUM_SRC-1:0] irq_ack,
    output logic [PSW_W-1:0]   psw,
    output logic [PC_W-1:0]    ret_pc,
    output logic [PSW_W-1:0]   saved_psw
);
    logic             req_any;
    logic [IDX_W-1:0] req_idx;
    ent_state_e       state;
    logic [IDX_W-1:0] src;
    ent_ctl_t         ctl;

    irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req (irq_req),
        .any (req_any),
        .idx (req_idx)
    );

    irq_entry_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .take     (req_any && psw[GIE_BIT]),
        .pick_idx (req_idx),
        .state    (state),
        .src      (src)
    );

    irq_ctx_save #(
        .PC_W    (PC_W),
        .PSW_W   (PSW_W),
        .GIE_BIT (GIE_BIT),
        .PSW_RST ('0)
    ) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .save        (ctl.save),
        .pc_decode   (pc_decode),
        .psw_wr_en   (psw_wr_en),
        .psw_wr_data (psw_wr_data),
        .psw         (psw),
        .ret_pc      (ret_pc),
        .saved_psw   (saved_psw)
    );

    always_comb begin
        ctl = ctl_of(state);
    end

    assign flush_fetch  = ctl.squash;
    assign flush_decode = ctl.squash;
    assign vec_rd_en    = ctl.vec_rd;
    assign vec_rd_idx   = src;
    assign pc_load_en   = ctl.pc_load;
    assign pc_load_val  = vec_rd_data;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
        assign irq_ack[g] = ctl.vec_rd && (src == IDX_W'(g));
    end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int NUM_SRC = 8,
    parameter int PC_W    = 16,
    parameter int PSW_W   = 16,
    parameter int GIE_BIT = 0,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    pc_decode,
    input logic               vec_rd_en,
    input logic               flush_fetch,
    input logic               flush_decode,
    input logic               pc_load_en,
    input logic [NUM_SRC-1:0] irq_ack,
    input logic [PSW_W-1:0]   psw,
    input logic [PC_W-1:0]    ret_pc
);
    // R2
    abort_then_load_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_en |=> (pc_load_en && flush_fetch && flush_decode));

    // R4
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_en |=> (!pc_load_en && !flush_fetch && !flush_decode));

    // R3
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_en |-> ($countones(irq_ack) == 1));

    // R3
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_rd_en |-> (irq_ack == '0));

    // R6
    ret_pc_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_en |=> (ret_pc == $past(pc_decode)));

    // R7
    gie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_en |-> !psw[GIE_BIT]);

    // R8
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!psw[GIE_BIT] && !flush_fetch) |=> !flush_fetch);
endmodule

bind irq_entry_ctrl irq_entry_chk #(
    .NUM_SRC (NUM_SRC),
    .PC_W    (PC_W),
    .PSW_W   (PSW_W),
    .GIE_BIT (GIE_BIT),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc_decode    (pc_decode),
    .vec_rd_en    (vec_rd_en),
    .flush_fetch  (flush_fetch),
    .flush_decode (flush_decode),
    .pc_load_en   (pc_load_en),
    .irq_ack      (irq_ack),
    .psw          (psw),
    .ret_pc       (ret_pc)
);

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
    localparam int T = 10;

    typedef struct packed {
        logic [7:0]  lines;
        logic [15:0] pcd;
        logic        wr;
        logic [15:0] wdata;
        logic [2:0]  idx;
        logic [3:0]  off;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h01, 16'h0120, 1'b0, 16'h0000, 3'd0, 4'd1},
        '{8'h80, 16'h0344, 1'b0, 16'h0000, 3'd7, 4'd9},
        '{8'hA4, 16'h0FFE, 1'b1, 16'h5A01, 3'd2, 4'd5},
        '{8'hFF, 16'h7000, 1'b0, 16'h0000, 3'd0, 4'd3},
        '{8'h18, 16'h0002, 1'b1, 16'h0000, 3'd3, 4'd7},
        '{8'h60, 16'hFFFE, 1'b0, 16'h0000, 3'd5, 4'd2}
    };
    localparam logic [15:0] PRE_PSW = 16'h8001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_req = '0;
    logic [15:0] pc_decode = '0;
    logic        psw_wr_en = 1'b0;
    logic [15:0] psw_wr_data = '0;
    logic        vec_rd_en;
    logic [2:0]  vec_rd_idx;
    logic [15:0] vec_rd_data = '0;
    logic        flush_fetch, flush_decode, pc_load_en;
    logic [15:0] pc_load_val;
    logic [7:0]  irq_ack;
    logic [15:0] psw, ret_pc, saved_psw;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(T/2) clk = ~clk;

    irq_entry_ctrl uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .pc_decode(pc_decode),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .vec_rd_en(vec_rd_en), .vec_rd_idx(vec_rd_idx), .vec_rd_data(vec_rd_data),
        .flush_fetch(flush_fetch), .flush_decode(flush_decode),
        .pc_load_en(pc_load_en), .pc_load_val(pc_load_val), .irq_ack(irq_ack),
        .psw(psw), .ret_pc(ret_pc), .saved_psw(saved_psw)
    );

    function automatic logic [15:0] vtab(input logic [2:0] i);
        return 16'h1000 + {7'b0, i, 6'b0};
    endfunction

    always_ff @(posedge clk) begin
        if (vec_rd_en) vec_rd_data <= vtab(vec_rd_idx);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_psw(input logic [15:0] v);
        psw_wr_en   = 1'b1;
        psw_wr_data = v;
        @(posedge clk); #1;
        psw_wr_en   = 1'b0;
    endtask

    task automatic entry(input logic [7:0] lines, input logic [15:0] pcd,
                         input logic wr, input logic [15:0] wdata,
                         input logic [2:0] idx, input int off);
        longint t_req, lat;
        logic [15:0] exp_saved;
        set_psw(PRE_PSW);
        #(off - 1);
        irq_req   = lines;
        pc_decode = pcd;
        t_req     = $time;
        @(posedge clk); #1;
        chk("R2 flush_fetch in abort", flush_fetch, 1);
        chk("R2 flush_decode in abort", flush_decode, 1);
        chk("R3 vec_rd_en", vec_rd_en, 1);
        chk("R5 lowest index picked", vec_rd_idx, idx);
        chk("R3 irq_ack one-hot", irq_ack, 8'h01 << idx);
        psw_wr_en   = wr;
        psw_wr_data = wdata;
        irq_req     = '0;
        @(posedge clk); #1;
        psw_wr_en = 1'b0;
        exp_saved = wr ? wdata : PRE_PSW;
        chk("R4 pc_load_en", pc_load_en, 1);
        chk("R4 pc_load_val", pc_load_val, vtab(idx));
        chk("R2 flush held in load", {flush_fetch, flush_decode}, 2'b11);
        chk("R6 ret_pc", ret_pc, pcd);
        chk("R7 saved_psw", saved_psw, exp_saved);
        chk("R7 psw enable cleared", psw, exp_saved & 16'hFFFE);
        chk("R3 no ack in load", irq_ack, 0);
        @(posedge clk);
        lat = $time - t_req;
        chk("R4 latency window", (lat > 2*T && lat < 3*T), 1);
        #1;
        chk("R4 entry finished", {pc_load_en, flush_fetch, flush_decode, vec_rd_en}, 0);
    endtask

    initial begin
        #(T * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 outputs in reset", {flush_fetch, flush_decode, vec_rd_en, pc_load_en}, 0);
        chk("R1 psw reset", psw, 0);
        rst = 1'b0;
        irq_req = 8'hFF;
        @(posedge clk); #1;
        chk("R1 idle after reset", {flush_fetch, vec_rd_en, pc_load_en, irq_ack}, 0);
        chk("R1 saved regs reset", {ret_pc, saved_psw}, 0);
        irq_req = '0;

        for (int k = 0; k < 6; k++) begin
            entry(VECS[k].lines, VECS[k].pcd, VECS[k].wr, VECS[k].wdata,
                  VECS[k].idx, int'(VECS[k].off));
        end

        // R4 random sub-cycle arrival offsets
        for (int k = 0; k < 8; k++) begin
            entry(8'h10, 16'h0200 + 16'(k), 1'b0, 16'h0, 3'd4, $urandom_range(1, T - 1));
        end

        // R8 masked requests ignored; R10 plain write
        set_psw(16'h0040);
        chk("R10 psw write", psw, 16'h0040);
        irq_req = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk("R8 masked no flush", {flush_fetch, flush_decode, vec_rd_en, pc_load_en}, 0);
        end
        chk("R8 psw unchanged", psw, 16'h0040);
        irq_req = '0;

        // R9 held request does not restart an entry in progress
        set_psw(PRE_PSW);
        #3;
        irq_req = 8'h06;
        @(posedge clk); #1;
        chk("R9 first entry idx", vec_rd_idx, 1);
        @(posedge clk); #1;
        chk("R9 load cycle", pc_load_en, 1);
        psw_wr_en   = 1'b1;
        psw_wr_data = PRE_PSW;
        @(posedge clk); #1;
        psw_wr_en = 1'b0;
        chk("R9 no restart after load", {flush_fetch, vec_rd_en}, 0);
        chk("R10 re-enable write", psw, PRE_PSW);
        @(posedge clk); #1;
        chk("R9 next entry starts", {flush_fetch, vec_rd_en}, 2'b11);
        chk("R9 next entry idx", vec_rd_idx, 1);
        irq_req = '0;
        @(posedge clk); @(posedge clk); #1;
        chk("R9 back to idle", {flush_fetch, pc_load_en}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule